// File: doc/BRIEF.md
# Decimating FIR Multiply-Accumulate Tap Cell

This block is a single tap of a cascadable FIR filter array. Every clock it can capture a 9-bit signal sample and a 9-bit coefficient. It multiplies the two captured operands and adds the product into a 26-bit signed accumulator. An external output stage reads that accumulator.

The coefficient also runs through a short chain of resampling registers and leaves the cell toward the next tap. A 2-bit select picks how deep in the chain the outgoing coefficient is taken. This sets how many samples apart neighbouring taps see the same coefficient, and so gives decimation by 1, 2, 3 or 4 across the array.

Each operand has its own mode bit that reads it either as a signed 9-bit value or as an unsigned 8-bit value. A clear input starts a new sum by loading the product instead of adding it, so back-to-back output sums need no idle cycle.

Top module: `fir_tap_cell`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears the accumulator, the operand registers and every coefficient delay register, so `accOut` and `coefOut` read zero after the edge.
- R2: Inputs presented before rising edge k are captured at edge k. Their product is added into `accOut` at edge k+1, so the result is visible after two edges.
- R3: A mode bit of 1 reads its operand as unsigned, using bits 7:0 only and ignoring bit 8. A mode bit of 0 reads the full 9-bit field as two's complement. `dataUnsigned` and `coefUnsigned` act independently and are captured together with the operands.
- R4: While `dataEn` is low, the captured sample holds its value and a changing `dataIn` has no effect on the products accumulated.
- R5: While `coefEn` is low, the captured coefficient and the whole delay chain hold, so `coefOut` does not change for a fixed `decSel`.
- R6: When `accClear` is high with the operands it is captured with, the accumulator loads that product and discards the old sum. A clear on consecutive cycles gives each product alone.
- R7: `coefOut` equals the coefficient accepted `decSel`+1 coefficient-enabled edges earlier: `decSel` 0 gives the captured coefficient, and 1, 2 and 3 give one, two or three extra resampling stages.
- R8: The accumulator holds exact signed sums of up to 511 products of any operand values, including 511 products of -256 by -256 (33,488,896).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 9 | Signal sample |
| dataEn | input | 1 | Capture enable for the sample |
| dataUnsigned | input | 1 | 1: sample is unsigned 8-bit; 0: signed 9-bit |
| coefIn | input | 9 | Coefficient from the previous cell |
| coefEn | input | 1 | Capture and shift enable for the coefficient path |
| coefUnsigned | input | 1 | 1: coefficient is unsigned 8-bit; 0: signed 9-bit |
| decSel | input | 2 | Number of extra resampling stages on the coefficient path |
| accClear | input | 1 | Start a new sum with this product |
| coefOut | output | 9 | Coefficient toward the next cell |
| accOut | output | 26 | Accumulator value for the output stage |

## Verification
A corrupted operand register, or a wrong mode flag, shows up in `accOut` one edge after the bad value is captured. Most of the sweep clears on every cycle, so each such fault appears as a single wrong product and cannot hide in a running sum. A wrong delay-chain stage reaches `coefOut` at once for the `decSel` that selects it, and reaches deeper selects one coefficient-enabled edge per stage later. A sign or width fault in the accumulator is only visible near the top of its range, which the long run of maximum products reaches.

// File: rtl/fir_tap_pkg.sv
package fir_tap_pkg;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic dataLoad;  // capture sample this edge
    logic coefLoad;  // capture and shift coefficient path this edge
    logic accClr;    // registered: current operands start a new sum
    logic dataUns;   // registered: captured sample is unsigned
    logic coefUns;   // registered: captured coefficient is unsigned
  } tapStrobe_t;

endpackage

// File: rtl/fir_tap_ctrl.sv
module fir_tap_ctrl
  import fir_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dataEn,
  input  logic       coefEn,
  input  logic       accClear,
  input  logic       dataUnsigned,
  input  logic       coefUnsigned,
  output tapStrobe_t strb
);

  logic clrQ, dUnsQ, cUnsQ;

  // Mode and clear travel one stage so they line up with the captured operands
  always_ff @(posedge clk) begin
    if (rst) begin
      clrQ  <= 1'b0;
      dUnsQ <= 1'b0;
      cUnsQ <= 1'b0;
    end else begin
      clrQ  <= accClear;
      dUnsQ <= dataUnsigned;
      cUnsQ <= coefUnsigned;
    end
  end

  always_comb begin
    strb.dataLoad = dataEn;
    strb.coefLoad = coefEn;
    strb.accClr   = clrQ;
    strb.dataUns  = dUnsQ;
    strb.coefUns  = cUnsQ;
  end

endmodule

// File: rtl/fir_tap_dp.sv
module fir_tap_dp
  import fir_tap_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int COEF_W  = 9,
  parameter int ACC_W   = 26,
  parameter int NUM_DLY = 3,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  tapStrobe_t        strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [COEF_W-1:0] coefIn,
  input  logic [SEL_W-1:0]  decSel,
  output logic [COEF_W-1:0] coefOut,
  output logic [ACC_W-1:0]  accOut
);

  localparam int DX_W   = DATA_W + 1;
  localparam int CX_W   = COEF_W + 1;
  localparam int PROD_W = DX_W + CX_W;

  logic [DATA_W-1:0] dataReg;
  logic [COEF_W-1:0] stage [NUM_DLY+1];
  logic signed [DX_W-1:0]   opData;
  logic signed [CX_W-1:0]   opCoef;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0] prodExt;
  logic [ACC_W-1:0] acc;

  // Operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg  <= '0;
      stage[0] <= '0;
    end else begin
      if (strb.dataLoad) dataReg  <= dataIn;
      if (strb.coefLoad) stage[0] <= coefIn;
    end
  end

  // Resampling chain on the coefficient path
  for (genvar i = 1; i <= NUM_DLY; i++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst)                stage[i] <= '0;
      else if (strb.coefLoad) stage[i] <= stage[i-1];
    end
  end

  always_comb begin
    if (int'(decSel) > NUM_DLY) coefOut = stage[NUM_DLY];
    else                        coefOut = stage[decSel];
  end

  // Operand extension: unsigned uses the low bits only
  always_comb begin
    opData = strb.dataUns ? signed'({2'b00, dataReg[DATA_W-2:0]})
                          : signed'({dataReg[DATA_W-1], dataReg});
    opCoef = strb.coefUns ? signed'({2'b00, stage[0][COEF_W-2:0]})
                          : signed'({stage[0][COEF_W-1], stage[0]});
    prod    = opData * opCoef;
    prodExt = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  always_ff @(posedge clk) begin
    if (rst)              acc <= '0;
    else if (strb.accClr) acc <= prodExt;
    else                  acc <= acc + prodExt;
  end

  assign accOut = acc;

  // Held sample stays put
  p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !strb.dataLoad |=> $stable(dataReg));

  // Frozen coefficient path keeps the outgoing coefficient
  p_coef_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !strb.coefLoad |=> ($stable(decSel) -> $stable(coefOut)));

  // Two unsigned operands never form a negative product
  p_unsigned_nonneg_r3: assert property (@(posedge clk) disable iff (rst)
    (strb.dataUns && strb.coefUns) |-> !prod[PROD_W-1]);

  // A zero operand leaves a running sum untouched
  p_zero_term_r2: assert property (@(posedge clk) disable iff (rst)
    (!strb.accClr && (dataReg == '0 || stage[0] == '0)) |=> $stable(acc));

endmodule

// File: rtl/fir_tap_cell.sv
module fir_tap_cell
  import fir_tap_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int COEF_W  = 9,
  parameter int ACC_W   = 26,
  parameter int NUM_DLY = 3,
  localparam int SEL_W  = $clog2(NUM_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataEn,
  input  logic              dataUnsigned,
  input  logic [COEF_W-1:0] coefIn,
  input  logic              coefEn,
  input  logic              coefUnsigned,
  input  logic [SEL_W-1:0]  decSel,
  input  logic              accClear,
  output logic [COEF_W-1:0] coefOut,
  output logic [ACC_W-1:0]  accOut
);

  tapStrobe_t strb;

  fir_tap_ctrl ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .dataEn       (dataEn),
    .coefEn       (coefEn),
    .accClear     (accClear),
    .dataUnsigned (dataUnsigned),
    .coefUnsigned (coefUnsigned),
    .strb         (strb)
  );

  fir_tap_dp #(
    .DATA_W  (DATA_W),
    .COEF_W  (COEF_W),
    .ACC_W   (ACC_W),
    .NUM_DLY (NUM_DLY),
    .SEL_W   (SEL_W)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .dataIn  (dataIn),
    .coefIn  (coefIn),
    .decSel  (decSel),
    .coefOut (coefOut),
    .accOut  (accOut)
  );

endmodule

// File: tb/fir_tap_cell_tb_top.sv
`timescale 1ns/1ps
module fir_tap_cell_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [8:0] dataIn;
  logic       dataEn;
  logic       dataUnsigned;
  logic [8:0] coefIn;
  logic       coefEn;
  logic       coefUnsigned;
  logic [1:0] decSel;
  logic       accClear;
  logic [8:0] coefOut;
  logic [25:0] accOut;

  int vecCnt  = 0;
  int failCnt = 0;

  // reference state, built from the requirements
  int mData, mCoef, mUd, mUc, mClr;
  int mStage [4];
  longint mAcc;

  always #2.5 clk = ~clk;

  fir_tap_cell dut_i (
    .clk (clk), .rst (rst),
    .dataIn (dataIn), .dataEn (dataEn), .dataUnsigned (dataUnsigned),
    .coefIn (coefIn), .coefEn (coefEn), .coefUnsigned (coefUnsigned),
    .decSel (decSel), .accClear (accClear),
    .coefOut (coefOut), .accOut (accOut)
  );

  function automatic longint extOp(input int raw, input int uns);
    if (uns != 0) return longint'(raw % 256);
    if (raw >= 256) return longint'(raw - 512);
    return longint'(raw);
  endfunction

  task automatic compare(input string tag, input int dsel);
    longint gotAcc;
    gotAcc = longint'($signed(accOut));
    vecCnt++;
    if (gotAcc != mAcc) begin
      failCnt++;
      $display("FAIL %s accOut got %0d expected %0d", tag, gotAcc, mAcc);
    end
    if (int'(coefOut) != mStage[dsel]) begin
      failCnt++;
      $display("FAIL %s coefOut got %0d expected %0d", tag, coefOut, mStage[dsel]);
    end
  endtask

  task automatic step(input int din, input int den, input int cin, input int cen,
                      input int clr, input int ud, input int uc, input int dsel,
                      input string tag);
    longint p;
    dataIn = din[8:0]; dataEn = den[0]; coefIn = cin[8:0]; coefEn = cen[0];
    accClear = clr[0]; dataUnsigned = ud[0]; coefUnsigned = uc[0]; decSel = dsel[1:0];
    @(posedge clk);
    p = extOp(mData, mUd) * extOp(mCoef, mUc);
    mAcc = (mClr != 0) ? p : mAcc + p;
    if (den != 0) mData = din;
    if (cen != 0) begin
      mStage[3] = mStage[2]; mStage[2] = mStage[1];
      mStage[1] = mStage[0]; mStage[0] = cin;
      mCoef = cin;
    end
    mUd = ud; mUc = uc; mClr = clr;
    #1;
    compare(tag, dsel);
  endtask

  task automatic doReset();
    rst = 1'b1;
    dataIn = 9'h1AB; dataEn = 1'b1; coefIn = 9'h155; coefEn = 1'b1;
    accClear = 1'b0; dataUnsigned = 1'b0; coefUnsigned = 1'b0; decSel = 2'd3;
    repeat (2) @(posedge clk);
    #1;
    mData = 0; mCoef = 0; mUd = 0; mUc = 0; mClr = 0; mAcc = 0;
    foreach (mStage[i]) mStage[i] = 0;
    compare("R1", 3);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    #(5.0 * 190000);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin : main
    doReset();

    // R3 / R2: every sample value against a spread of coefficients, all four modes
    for (int mode = 0; mode < 4; mode++) begin
      for (int d = 0; d < 512; d++) begin
        for (int k = 0; k < 20; k++) begin
          int c;
          if (k < 16) c = k * 33;
          else if (k == 16) c = 255;
          else if (k == 17) c = 256;
          else if (k == 18) c = 257;
          else c = 511;
          step(d, 1, c, 1, 1, mode & 1, mode >> 1, 0, "R3");
        end
      end
    end

    // R2: running sums with mixed signs and modes
    step(100, 1, 7, 1, 1, 0, 0, 0, "R2");
    for (int i = 0; i < 60; i++)
      step((i * 71 + 3) % 512, 1, (i * 113 + 9) % 512, 1, 0, (i / 7) & 1, (i / 11) & 1, 0, "R2");

    // R6: clear mid-stream, then back-to-back clears
    step(300, 1, 20, 1, 1, 0, 0, 0, "R6");
    step(45, 1, 500, 1, 1, 0, 1, 0, "R6");
    step(511, 1, 511, 1, 1, 1, 1, 0, "R6");
    step(12, 1, 13, 1, 0, 0, 0, 0, "R6");
    step(12, 1, 13, 1, 0, 0, 0, 0, "R6");

    // R4: sample enable low while dataIn keeps changing
    step(77, 1, 5, 1, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 8; i++)
      step(400 + i, 0, 5 + i, 1, 0, 0, 0, 0, "R4");

    // R7: coefficient path depth for each select
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 12; i++)
        step(1, 1, (s * 97 + i * 29 + 1) % 512, 1, 1, 0, 0, s, "R7");
    end

    // R5: coefficient enable low, coefIn changing, every select
    for (int s = 0; s < 4; s++) begin
      step(3, 1, 200 + s, 1, 1, 0, 0, s, "R5");
      for (int i = 0; i < 5; i++)
        step(3, 1, 17 * i + 60, 0, 0, 0, 0, s, "R5");
    end

    // R8: 511 products of -256 by -256
    step(256, 1, 256, 1, 1, 0, 0, 0, "R8");
    for (int i = 0; i < 510; i++)
      step(256, 1, 256, 1, 0, 0, 0, 0, "R8");
    step(0, 1, 0, 1, 1, 0, 0, 0, "R8");
    vecCnt++;
    if (mAcc != 64'sd33488896 || longint'($signed(accOut)) != 64'sd33488896) begin
      failCnt++;
      $display("FAIL R8 accOut got %0d expected %0d", $signed(accOut), 33488896);
    end

    // R1: reset in the middle of activity
    step(90, 1, 91, 1, 0, 0, 0, 2, "R1");
    doReset();
    step(0, 1, 0, 1, 0, 0, 0, 3, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

endmodule